// File: doc/BRIEF.md
# EEPROM Mode and Configuration-Lock Register

This block is the 8-bit command register that chooses how a network controller runs. Bits 7:6 hold a mode field. In normal mode the controller works as usual. In load mode a small engine reads the serial configuration EEPROM, then returns the field to normal and pulses a reset to the other registers. In programming mode software drives the EEPROM pins directly, and network and bus-master traffic are held off. In unlock mode writes to the protected configuration registers are allowed.

Software reaches the block through a one-cycle write strobe and a combinational read bus. The block's outputs are the three EEPROM control pins, one gate for protected writes, one gate that stops network and bus-master activity, and the register-reset pulse. The load time is a parameter counted in clock cycles. The default gives 2 ms at 100 MHz.

Top module: `eeprom_mode_ctrl`

## Requirements
- R1: After reset the mode is 00 (normal), `reg_rdata` is 0x00, and `ee_cs`, `ee_sk`, `ee_di`, `cfg_wr_en`, `net_disable` and `regs_reset` are all low.
- R2: A write outside load mode stores `reg_wdata[7:6]` as the mode. The mode reads back on `reg_rdata[7:6]`. The encodings are 00 = normal, 01 = load, 10 = programming and 11 = unlock.
- R3: `reg_rdata[5:4]` always reads 00, whatever value was written to those bits.
- R4: Writing mode 01 starts a load. The mode reads 01 for exactly LOAD_CYCLES cycles after the write edge. It then returns to 00 without any software write.
- R5: When a load ends, `regs_reset` is high for exactly one cycle, in the same cycle the mode first reads 00 again. The pulse does not lock the register: a later write still takes effect.
- R6: Every write made while the mode is 01 is ignored. The mode and the pins keep following the load engine.
- R7: In mode 10, `net_disable` is high. Written bits 3, 2 and 1 drive `ee_cs`, `ee_sk` and `ee_di` respectively. `reg_rdata[0]` shows the live `ee_do` input.
- R8: `cfg_wr_en` is high exactly while the mode is 11.
- R9: During a load, `ee_cs` stays high and `ee_sk` toggles every SK_HALF cycles. On successive rising edges of `ee_sk`, `ee_di` carries the read command 1, 1, 0 followed by ADDR_W zero address bits, most significant bit first. After that `ee_di` stays low. `reg_rdata[3:0]` shows `{ee_cs, ee_sk, ee_di, ee_do}`.
- R10: In modes 00 and 11, `ee_cs`, `ee_sk` and `ee_di` are low and `reg_rdata[3:0]` reads 0. Pin bits written in programming mode are not kept after leaving that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| cfg_wr_en | output | 1 | Allows writes to protected configuration bits |
| net_disable | output | 1 | Stops network and bus-master activity |
| regs_reset | output | 1 | One-cycle reset pulse to the other registers |

## Verification
The bench builds the block with LOAD_CYCLES = 64, SK_HALF = 2 and ADDR_W = 6. With these values a complete load fits in a few dozen cycles. The bench can therefore run the exact cycle count, the reset pulse, the rejected writes and the whole 9-bit command on `ee_di` several times in one short run. The small SK_HALF gives about sixteen serial-clock rising edges per load, so the zero tail after the command is also checked.

// File: rtl/eeprom_mode_ctrl.sv
module eeprom_mode_ctrl #(
  parameter int LOAD_CYCLES = 200000,
  parameter int SK_HALF     = 25,
  parameter int ADDR_W      = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       ee_cs,
  output logic       ee_sk,
  output logic       ee_di,
  input  logic       ee_do,
  output logic       cfg_wr_en,
  output logic       net_disable,
  output logic       regs_reset
);

  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_LOAD = 2'b01;
  localparam logic [1:0] M_PROG = 2'b10;
  localparam logic [1:0] M_UNLK = 2'b11;
  localparam int CMD_W = 3 + ADDR_W;
  localparam int CW    = $clog2(LOAD_CYCLES + 1);
  localparam int SW    = $clog2(SK_HALF + 1);
  localparam int BW    = $clog2(CMD_W + 1);
  localparam logic [CW-1:0]    LAST_CNT = CW'(LOAD_CYCLES - 1);
  localparam logic [SW-1:0]    LAST_SK  = SW'(SK_HALF - 1);
  localparam logic [BW-1:0]    ALL_BITS = BW'(CMD_W);
  localparam logic [CMD_W-1:0] RD_CMD   = {3'b110, {ADDR_W{1'b0}}};

  logic [1:0]       mode;
  logic [2:0]       pin_q;
  logic [CW-1:0]    cnt;
  logic [SW-1:0]    sk_cnt;
  logic             sk_q;
  logic [BW-1:0]    bit_idx;
  logic             rst_pulse;
  logic [CMD_W-1:0] cmd_sh;

  wire loading = (mode == M_LOAD);
  wire prog    = (mode == M_PROG);
  wire done    = loading && (cnt == LAST_CNT);

  assign cmd_sh = RD_CMD << bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_NORM;
      pin_q     <= '0;
      cnt       <= '0;
      sk_cnt    <= '0;
      sk_q      <= 1'b0;
      bit_idx   <= '0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= 1'b0;
      if (loading) begin
        if (done) begin
          mode      <= M_NORM;
          rst_pulse <= 1'b1;
          cnt       <= '0;
          sk_cnt    <= '0;
          sk_q      <= 1'b0;
          bit_idx   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
          if (sk_cnt == LAST_SK) begin
            sk_cnt <= '0;
            sk_q   <= ~sk_q;
            if (sk_q && bit_idx != ALL_BITS) bit_idx <= bit_idx + 1'b1;
          end else begin
            sk_cnt <= sk_cnt + 1'b1;
          end
        end
      end else if (reg_wr) begin
        mode    <= reg_wdata[7:6];
        pin_q   <= (reg_wdata[7:6] == M_PROG) ? reg_wdata[3:1] : 3'b000;
        cnt     <= '0;
        sk_cnt  <= '0;
        sk_q    <= 1'b0;
        bit_idx <= '0;
      end
    end
  end

  assign ee_cs       = loading | (prog & pin_q[2]);
  assign ee_sk       = loading ? sk_q : (prog & pin_q[1]);
  assign ee_di       = loading ? cmd_sh[CMD_W-1] : (prog & pin_q[0]);
  assign cfg_wr_en   = (mode == M_UNLK);
  assign net_disable = prog;
  assign regs_reset  = rst_pulse;
  assign reg_rdata   = {mode, 2'b00, (loading | prog) ? {ee_cs, ee_sk, ee_di, ee_do} : 4'b0000};

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    regs_reset |=> !regs_reset); // R5
  AST_LOAD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_LOAD && mode != M_LOAD) |-> (regs_reset && mode == M_NORM)); // R4
  AST_LOAD_IGNORES_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && !done && reg_wr) |=> (mode == M_LOAD)); // R6
  AST_UNLOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !loading && reg_wdata[7:6] == M_UNLK) |=> cfg_wr_en); // R8
  AST_PROG_NET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !loading && reg_wdata[7:6] == M_PROG) |=> net_disable); // R7

endmodule

// File: tb/eeprom_mode_ctrl_bench.sv
module eeprom_mode_ctrl_bench;
  localparam int LOAD   = 64;
  localparam int SKH    = 2;
  localparam int AW     = 6;
  localparam int CMDW   = 3 + AW;

  logic clk = 0, rst_n = 0, reg_wr = 0, ee_do = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic ee_cs, ee_sk, ee_di, cfg_wr_en, net_disable, regs_reset;
  int tests = 0, fails = 0;

  eeprom_mode_ctrl #(.LOAD_CYCLES(LOAD), .SK_HALF(SKH), .ADDR_W(AW)) u_eeprom_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .cfg_wr_en(cfg_wr_en), .net_disable(net_disable), .regs_reset(regs_reset));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [1:0] m, logic [2:0] p, logic d);
    return {m, 2'b00, (m == 2'b10) ? {p, d} : 4'b0000};
  endfunction

  function automatic logic cmd_bit(int k);
    return (k == 0 || k == 1) ? 1'b1 : 1'b0;
  endfunction

  task automatic wr(logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic run_load(logic [7:0] junk);
    int n = 0, nb = 0;
    logic prev_sk = 0;
    wr(8'h40);
    while (reg_rdata[7:6] == 2'b01 && n < LOAD + 4) begin
      n++;
      chk("R9 cs high", ee_cs, 1);
      chk("R9 readback pins", reg_rdata[3:0], {ee_cs, ee_sk, ee_di, ee_do});
      chk("R4 no early pulse", regs_reset, 0);
      if (!prev_sk && ee_sk) begin
        chk("R9 command bit", ee_di, (nb < CMDW) ? cmd_bit(nb) : 1'b0);
        nb++;
      end
      prev_sk = ee_sk;
      reg_wr = (n == 5 || n == 20);
      reg_wdata = junk;
      @(negedge clk);
    end
    reg_wr = 0;
    chk("R4 load length", n, LOAD);
    chk("R6 writes ignored, mode back to 00", reg_rdata, 8'h00);
    chk("R5 reset pulse", regs_reset, 1);
    chk("R9 enough sk edges", nb > CMDW, 1);
    @(negedge clk);
    chk("R5 pulse one wide", regs_reset, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 outputs", {ee_cs, ee_sk, ee_di, cfg_wr_en, net_disable, regs_reset}, 0);
    rst_n = 1;
    @(negedge clk);

    wr(8'hB7);
    chk("R2 mode 10", reg_rdata[7:6], 2'b10);
    chk("R3 reserved zero", reg_rdata[5:4], 0);
    chk("R7 pins", {ee_cs, ee_sk, ee_di}, 3'b011);
    chk("R7 net off", net_disable, 1);
    ee_do = 1; #1;
    chk("R7 live do", reg_rdata[0], 1);
    ee_do = 0;
    wr(8'hFF);
    chk("R8 unlock", cfg_wr_en, 1);
    chk("R10 quiet in 11", {ee_cs, ee_sk, ee_di, reg_rdata[3:0]}, 0);
    wr(8'h9E);
    wr(8'h00);
    chk("R10 pins not retained", {ee_cs, ee_sk, ee_di}, 0);
    chk("R8 locked", cfg_wr_en, 0);

    run_load(8'hBE);
    wr(8'hC0);
    chk("R5 write after pulse", reg_rdata, 8'hC0);
    run_load(8'h40);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] v;
      logic [1:0] m;
      v = 8'($urandom);
      m = v[7:6];
      if (m == 2'b01) m = 2'b10;
      v[7:6] = m;
      ee_do = 1'($urandom);
      wr(v);
      chk("R2/R3/R10 rdata", reg_rdata, exp_rd(m, (m == 2'b10) ? v[3:1] : 3'b000, ee_do));
      chk("R7/R10 pins", {ee_cs, ee_sk, ee_di}, (m == 2'b10) ? v[3:1] : 3'b000);
      chk("R8 gate", cfg_wr_en, m == 2'b11);
      chk("R7 net gate", net_disable, m == 2'b10);
      ee_do = ~ee_do; #1;
      chk("R7 live do", reg_rdata[0], (m == 2'b10) ? ee_do : 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule